// File: doc/BRIEF.md
# Three-Level to Two-Level Reference Vector Reducer

This block sits at the front of a three-level inverter modulator. Each phase of such an inverter can sit at one of three levels (N, O, P), which gives 27 switch combinations. Searching that space directly is costly. The vector diagram can instead be seen as six small hexagons, each shaped like a two-level diagram. Their centres sit on the six corners of the innermost hexagon, at a distance of one third of the DC link from the origin.

For each strobed reference vector, given in fixed-point alpha-beta form, the block picks the small hexagon whose centre is nearest in angle. It subtracts that centre from the reference. A plain two-level dwell-time stage and sequencer can then work on the result. The block also returns the hexagon number and a per-phase level offset. Adding the offset to the two-level switch states (0 or 1) gives the three-level level code of each phase. Results are registered and appear one clock after the strobe. They then hold until the next strobe.

Top module: `tl_hex_reducer`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `hex_idx`, `sh_alpha`, `sh_beta` and `phase_off` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle in which `in_valid` was sampled high. Back-to-back strobes give back-to-back valid cycles.
- R3: With c = 887/512 standing for the square root of three, the score of hexagon k is the dot product of (`ref_alpha`, `ref_beta`) with these directions: k=0 (2,0), k=1 (1,c), k=2 (-1,c), k=3 (-2,0), k=4 (-1,-c), k=5 (1,-c). `hex_idx` is the k with the highest score. A tie goes to the lower k.
- R4: Let Rc = 8192 (the one-third-link distance) and Hc = Rc·887/1024 = 7096. The centre of hexagon k in (alpha, beta) is: 0 (Rc,0), 1 (Rc/2,Hc), 2 (-Rc/2,Hc), 3 (-Rc,0), 4 (-Rc/2,-Hc), 5 (Rc/2,-Hc). A reference equal to a centre gives a zero shifted vector.
- R5: `sh_alpha`/`sh_beta` equal the reference minus the selected centre. The result is exact in 17-bit two's complement over the full 16-bit input range.
- R6: `phase_off` bit 0 is phase a, bit 1 is phase b and bit 2 is phase c. By hexagon it is: 0 → 001, 1 → 011, 2 → 010, 3 → 110, 4 → 100, 5 → 101. The level code N=0, O=1, P=2 equals the two-level bit plus the offset bit.
- R7: After a cycle with `in_valid` low, `hex_idx`, `sh_alpha`, `sh_beta` and `phase_off` keep their previous values, whatever the reference inputs carry.
- R8: The zero reference (origin) selects hexagon 0, and its shifted vector is (-Rc, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: sample the reference this cycle |
| ref_alpha | input | 16 | Reference alpha component, signed |
| ref_beta | input | 16 | Reference beta component, signed |
| out_valid | output | 1 | Result updated on this cycle |
| hex_idx | output | 3 | Selected small hexagon, 0 to 5 |
| sh_alpha | output | 17 | Alpha of reference minus centre, signed |
| sh_beta | output | 17 | Beta of reference minus centre, signed |
| phase_off | output | 3 | Per-phase level offset, bit 0 = phase a |

## Verification
The hardest cases are references that sit exactly on a boundary between two hexagons, where the tie rule decides the outcome. A random reference almost never lands there. The stimulus therefore places integer points exactly on the 30, 90, 150, 210, 270 and 330 degree lines, where (887, 512) and its mirror images make the scaled products cancel exactly. It also drives the origin, where all six scores tie. These directed points are followed by full-range extremes and long pseudo-random runs with strobe gaps, during which the held outputs are checked.

// File: rtl/tl_hex_reducer_pkg.sv
package tl_hex_reducer_pkg;

  // alpha coordinate of small-hexagon centre k at radius r
  function automatic int centre_alpha(input int k, input int r);
    case (k)
      0:       return r;
      1, 5:    return r / 2;
      2, 4:    return -(r / 2);
      default: return -r;
    endcase
  endfunction

  // beta coordinate of centre k; sqrt(3)/2 taken as sq3 / 2^(frac+1)
  function automatic int centre_beta(input int k, input int r, input int sq3, input int frac);
    int h;
    h = (r * sq3) >>> (frac + 1);
    case (k)
      1, 2:    return h;
      4, 5:    return -h;
      default: return 0;
    endcase
  endfunction

  // per-phase level offset, bit0 = phase a
  function automatic logic [2:0] level_offset(input int k);
    case (k)
      0:       return 3'b001;
      1:       return 3'b011;
      2:       return 3'b010;
      3:       return 3'b110;
      4:       return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/tl_sector_pick.sv
module tl_sector_pick #(
  parameter int W    = 16,
  parameter int FRAC = 9,
  parameter int SQ3  = 887
) (
  input  logic signed [W-1:0] alpha,
  input  logic signed [W-1:0] beta,
  output logic [5:0]          region,
  output logic [2:0]          idx
);
  localparam int PW = W + FRAC + 4;

  logic signed [PW-1:0] ax, bx, a_sc, b_sc, p_diff, q_sum;
  logic a_neg, a_zero, p_neg, p_zero, q_neg;

  assign ax     = PW'(alpha);
  assign bx     = PW'(beta);
  assign a_sc   = ax <<< FRAC;
  assign b_sc   = bx * PW'(SQ3);
  assign p_diff = a_sc - b_sc;   // sign splits hexagons 0/1 and 3/4
  assign q_sum  = a_sc + b_sc;   // sign splits hexagons 2/3 and 5/0
  assign a_neg  = alpha[W-1];
  assign a_zero = (alpha == '0);
  assign p_neg  = p_diff[PW-1];
  assign p_zero = (p_diff == '0);
  assign q_neg  = q_sum[PW-1];

  // ties resolved toward the lower hexagon number
  assign region[0] = !p_neg && !q_neg;
  assign region[1] = p_neg && !a_neg;
  assign region[2] = a_neg && !q_neg;
  assign region[3] = q_neg && (p_neg || p_zero);
  assign region[4] = !p_neg && !p_zero && (a_neg || a_zero);
  assign region[5] = !a_neg && !a_zero && q_neg;

  always_comb begin
    idx = '0;
    for (int k = 0; k < 6; k++) begin
      if (region[k]) idx = 3'(k);
    end
  end
endmodule

// File: rtl/tl_centre_table.sv
module tl_centre_table #(
  parameter int W    = 16,
  parameter int RAD  = 8192,
  parameter int FRAC = 9,
  parameter int SQ3  = 887
) (
  input  logic [2:0]        idx,
  output logic signed [W:0] cen_a,
  output logic signed [W:0] cen_b,
  output logic [2:0]        off
);
  localparam int NHEX = 6;

  logic signed [W:0] tab_a [NHEX];
  logic signed [W:0] tab_b [NHEX];
  logic [2:0]        tab_o [NHEX];

  for (genvar k = 0; k < NHEX; k++) begin : g_entry
    assign tab_a[k] = (W+1)'(tl_hex_reducer_pkg::centre_alpha(k, RAD));
    assign tab_b[k] = (W+1)'(tl_hex_reducer_pkg::centre_beta(k, RAD, SQ3, FRAC));
    assign tab_o[k] = tl_hex_reducer_pkg::level_offset(k);
  end

  always_comb begin
    cen_a = '0;
    cen_b = '0;
    off   = '0;
    for (int k = 0; k < NHEX; k++) begin
      if (idx == 3'(k)) begin
        cen_a = tab_a[k];
        cen_b = tab_b[k];
        off   = tab_o[k];
      end
    end
  end
endmodule

// File: rtl/tl_result_reg.sv
module tl_result_reg #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        d_idx,
  input  logic signed [W:0] d_sa,
  input  logic signed [W:0] d_sb,
  input  logic [2:0]        d_off,
  output logic              q_valid,
  output logic [2:0]        q_idx,
  output logic signed [W:0] q_sa,
  output logic signed [W:0] q_sb,
  output logic [2:0]        q_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_idx   <= '0;
      q_sa    <= '0;
      q_sb    <= '0;
      q_off   <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_idx <= d_idx;
        q_sa  <= d_sa;
        q_sb  <= d_sb;
        q_off <= d_off;
      end
    end
  end
endmodule

// File: rtl/tl_hex_reducer.sv
module tl_hex_reducer #(
  parameter int W    = 16,
  parameter int RAD  = 8192,
  parameter int FRAC = 9,
  parameter int SQ3  = 887
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic signed [W-1:0] ref_alpha,
  input  logic signed [W-1:0] ref_beta,
  output logic              out_valid,
  output logic [2:0]        hex_idx,
  output logic signed [W:0] sh_alpha,
  output logic signed [W:0] sh_beta,
  output logic [2:0]        phase_off
);
  logic [5:0]        region_hot;
  logic [2:0]        sel_idx;
  logic signed [W:0] cen_a, cen_b, diff_a, diff_b;
  logic [2:0]        sel_off;

  tl_sector_pick #(.W(W), .FRAC(FRAC), .SQ3(SQ3)) u_pick (
    .alpha (ref_alpha),
    .beta  (ref_beta),
    .region(region_hot),
    .idx   (sel_idx)
  );

  tl_centre_table #(.W(W), .RAD(RAD), .FRAC(FRAC), .SQ3(SQ3)) u_table (
    .idx  (sel_idx),
    .cen_a(cen_a),
    .cen_b(cen_b),
    .off  (sel_off)
  );

  assign diff_a = {ref_alpha[W-1], ref_alpha} - cen_a;
  assign diff_b = {ref_beta[W-1],  ref_beta}  - cen_b;

  tl_result_reg #(.W(W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid),
    .d_idx  (sel_idx),
    .d_sa   (diff_a),
    .d_sb   (diff_b),
    .d_off  (sel_off),
    .q_valid(out_valid),
    .q_idx  (hex_idx),
    .q_sa   (sh_alpha),
    .q_sb   (sh_beta),
    .q_off  (phase_off)
  );
endmodule

// File: rtl/tl_hex_reducer_chk.sv
module tl_hex_reducer_chk #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic signed [W-1:0] ref_alpha,
  input logic signed [W-1:0] ref_beta,
  input logic              out_valid,
  input logic [2:0]        hex_idx,
  input logic signed [W:0] sh_alpha,
  input logic signed [W:0] sh_beta,
  input logic [2:0]        phase_off,
  input logic [5:0]        region_hot,
  input logic signed [W:0] cen_a,
  input logic signed [W:0] cen_b
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  assert_region_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_hot) == 1);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hex_idx <= 3'd5);

  assert_shift_alpha_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid) |->
      ((sh_alpha + $past(cen_a)) == {$past(ref_alpha[W-1]), $past(ref_alpha)}));

  assert_shift_beta_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid) |->
      ((sh_beta + $past(cen_b)) == {$past(ref_beta[W-1]), $past(ref_beta)}));

  assert_offset_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones(phase_off) == (hex_idx[0] ? 2 : (hex_idx == 3'd0 && !$past(in_valid) && phase_off == 3'b000 ? 0 : 1))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !out_valid) |->
      ($stable(hex_idx) && $stable(sh_alpha) && $stable(sh_beta) && $stable(phase_off)));
endmodule

bind tl_hex_reducer tl_hex_reducer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ref_alpha (ref_alpha),
  .ref_beta  (ref_beta),
  .out_valid (out_valid),
  .hex_idx   (hex_idx),
  .sh_alpha  (sh_alpha),
  .sh_beta   (sh_beta),
  .phase_off (phase_off),
  .region_hot(region_hot),
  .cen_a     (cen_a),
  .cen_b     (cen_b)
);

// File: tb/tl_hex_reducer_tb.sv
`timescale 1ns/1ps
module tl_hex_reducer_tb;
  localparam int W    = 16;
  localparam int RAD  = 8192;
  localparam int HC   = (RAD * 887) / 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] ref_alpha = '0;
  logic signed [W-1:0] ref_beta  = '0;
  logic out_valid;
  logic [2:0] hex_idx;
  logic signed [W:0] sh_alpha, sh_beta;
  logic [2:0] phase_off;

  tl_hex_reducer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .ref_alpha(ref_alpha), .ref_beta(ref_beta),
    .out_valid(out_valid), .hex_idx(hex_idx),
    .sh_alpha(sh_alpha), .sh_beta(sh_beta), .phase_off(phase_off)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string in_tag = "";
  string ex_tag = "";

  bit     ex_v, ex_cap;
  int     ex_idx, ex_off;
  longint ex_sa, ex_sb;

  // nearest-direction choice, lower index wins ties (R3)
  function automatic int best_hex(input longint a, input longint b);
    longint sc [6];
    int best;
    sc[0] = 2 * a * 512;
    sc[1] = a * 512 + 887 * b;
    sc[2] = -a * 512 + 887 * b;
    sc[3] = -2 * a * 512;
    sc[4] = -a * 512 - 887 * b;
    sc[5] = a * 512 - 887 * b;
    best = 0;
    for (int k = 1; k < 6; k++) if (sc[k] > sc[best]) best = k;
    return best;
  endfunction

  function automatic longint cx(input int k);
    longint t [6] = '{RAD, RAD/2, -RAD/2, -RAD, -RAD/2, RAD/2};
    return t[k];
  endfunction

  function automatic longint cy(input int k);
    longint t [6] = '{0, HC, HC, 0, -HC, -HC};
    return t[k];
  endfunction

  function automatic int offs(input int k);
    int t [6] = '{1, 3, 2, 6, 4, 5};
    return t[k];
  endfunction

  // behavioural model, updated on the same edges as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_v = 0; ex_cap = 0; ex_idx = 0; ex_off = 0; ex_sa = 0; ex_sb = 0; ex_tag = "";
    end else begin
      ex_v   = in_valid;
      ex_cap = in_valid;
      if (in_valid) begin
        ex_idx = best_hex(longint'(ref_alpha), longint'(ref_beta));
        ex_sa  = longint'(ref_alpha) - cx(ex_idx);
        ex_sb  = longint'(ref_beta)  - cy(ex_idx);
        ex_off = offs(ex_idx);
        ex_tag = in_tag;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s [%s] actual %0d expected %0d", req, what, ex_tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string rq;
      if (!rst_n) rq = "R1";
      else if (!ex_cap) rq = "R7";
      else rq = "";
      chk(out_valid == ex_v, (rq == "R1") ? "R1" : "R2", "valid", longint'(out_valid), longint'(ex_v));
      chk(int'(hex_idx) == ex_idx, (rq == "") ? "R3" : rq, "hex_idx", longint'(hex_idx), longint'(ex_idx));
      chk(longint'(sh_alpha) == ex_sa, (rq == "") ? "R5" : rq, "sh_alpha", longint'(sh_alpha), ex_sa);
      chk(longint'(sh_beta) == ex_sb, (rq == "") ? "R5" : rq, "sh_beta", longint'(sh_beta), ex_sb);
      chk(int'(phase_off) == ex_off, (rq == "") ? "R6" : rq, "phase_off", longint'(phase_off), longint'(ex_off));
    end
  end

  task automatic apply(input int a, input int b, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    ref_alpha = W'(a);
    ref_beta  = W'(b);
    in_tag    = tag;
  endtask

  task automatic idle(input int a, input int b);
    @(negedge clk);
    in_valid  = 1'b0;
    ref_alpha = W'(a);
    ref_beta  = W'(b);
    in_tag    = "R7";
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    // R1: reset holds everything at zero, even with a strobe pending
    repeat (3) @(negedge clk);
    in_valid = 1'b1; ref_alpha = 16'sd1234; ref_beta = -16'sd77;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(0, 0);

    // R8: origin picks hexagon 0
    apply(0, 0, "R8");
    // R4: each centre yields a zero remainder
    for (int k = 0; k < 6; k++) apply(int'(cx(k)), int'(cy(k)), "R4");
    // R3: exact boundary ties
    apply(887, 512, "R3 30deg");
    apply(0, 100, "R3 90deg");
    apply(-887, 512, "R3 150deg");
    apply(-887, -512, "R3 210deg");
    apply(0, -100, "R3 270deg");
    apply(887, -512, "R3 330deg");
    apply(1, 0, "R3 near0");
    apply(-1, 0, "R3 180deg");
    // R5: full-range extremes
    apply(32767, 32767, "R5");
    apply(-32768, -32768, "R5");
    apply(-32768, 32767, "R5");
    apply(32767, -32768, "R5");
    // R7: held through gaps with changing inputs
    idle(-20000, 5000);
    idle(30000, -30000);
    idle(0, 0);
    // R2: back-to-back and isolated strobes
    apply(5000, 9000, "R2");
    apply(-5000, 9000, "R2");
    idle(1, 1);
    apply(12000, -3000, "R2");

    for (int i = 0; i < 4000; i++) begin
      int a, b;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      a = int'($signed(lfsr[15:0]));
      b = int'($signed(lfsr[31:16]));
      if (lfsr[3:2] == 2'b00) begin a = a >>> 6; b = b >>> 6; end
      if (lfsr[9:8] == 2'b11) idle(a, b);
      else apply(a, b, "rand");
    end
    idle(0, 0);
    idle(0, 0);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule